// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block is the CPU-facing control and status register that sequences self-programming of an on-chip flash. Software writes a byte that holds command bits together with an enable bit. That write opens a short acceptance window. A store-program strobe from the core inside the window starts exactly one flash operation: a temporary-buffer page load, a page erase, a page write, a lock-bit set, or a re-enable of the read-while-write section. If no strobe arrives in time, the pending command clears itself.

The block keeps a busy flag for the read-while-write section. An erase or a write that targets that section sets the flag, and the flag blocks reads of the section until software re-enables it or starts a page load. The block also drives single-cycle command pulses to the flash controller and a buffer-clear pulse. It lets a load-program strobe fetch lock or fuse bits shortly after a lock-bit command is armed, and it raises a ready interrupt while no operation is pending.

All pins are plain control and status signals. No data stream crosses this block, so no valid/ready handshake and no back-pressure apply. Command pulses are fire-and-forget, and the flash controller reports completion on `flash_done`.

Top module: `flash_selfprog_ctl`

## Requirements
- R1: After reset every register bit reads 0. The read byte holds interrupt-enable in bit 7, section-busy in bit 6, a constant 0 in bit 5, section-read-enable in bit 4, lock-set in bit 3, page-write in bit 2, page-erase in bit 1 and enable in bit 0. Bits 6 and 5 ignore software writes, and command bits written without bit 0 are not stored.
- R2: A write with bit 0 set, accepted while enable reads 0, stores bits 4..1 and sets enable. An `spm_strobe` sampled at any of the four clock edges after that write starts the operation. The matching command pulse is high for exactly the one cycle after that edge.
- R3: If no `spm_strobe` is sampled at those four edges, enable and bits 4..1 read 0 after the fourth edge and no command pulse is issued.
- R4: Each accepted strobe issues exactly one pulse. Section-read-enable wins over lock-set, lock-set wins over page-erase, and page-erase wins over page-write. With no command bit set, the pulse is `cmd_load`.
- R5: An erase or write started while `z_in_rww` is 1 sets section-busy, and `rww_blocked` follows it. With `z_in_rww` at 0, busy is unchanged.
- R6: For erase, write and lock-set, enable and the command bits stay set until `flash_done` is sampled. All of them read 0 after that edge.
- R7: A section-read-enable operation or a page load clears section-busy at its strobe edge and ends at once: enable reads 0 after that edge.
- R8: While enable reads 1, register writes change only bit 7. A re-enable request written then has no effect.
- R9: A register write with bit 4 set while `buf_loading` is 1 makes `buf_clear` high for the cycle after the write edge.
- R10: An `lpm_strobe` sampled at one of the three edges after arming lock-set with enable gives a one-cycle pulse: `lpm_lock_rd` when `lpm_z0` is 0, `lpm_fuse_rd` when it is 1. No pulse is given at later edges.
- R11: `spm_irq` equals interrupt-enable AND `global_ie` AND NOT enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| spm_strobe | input | 1 | Store-program instruction executed |
| lpm_strobe | input | 1 | Load-program instruction executed |
| lpm_z0 | input | 1 | Address pointer bit 0: 0 lock bits, 1 fuse bits |
| z_in_rww | input | 1 | Target page lies in the read-while-write section |
| global_ie | input | 1 | CPU global interrupt flag |
| flash_done | input | 1 | Flash controller finished erase, write or lock set |
| buf_loading | input | 1 | Temporary buffer load in progress |
| cmd_load | output | 1 | Page-load pulse |
| cmd_erase | output | 1 | Page-erase pulse |
| cmd_write | output | 1 | Page-write pulse |
| cmd_lock | output | 1 | Lock-bit-set pulse |
| cmd_rww_en | output | 1 | Section re-enable pulse |
| rww_blocked | output | 1 | Reads of the read-while-write section are blocked |
| buf_clear | output | 1 | Discard temporary buffer pulse |
| lpm_lock_rd | output | 1 | Return lock bits to the load-program instruction |
| lpm_fuse_rd | output | 1 | Return fuse bits to the load-program instruction |
| spm_irq | output | 1 | Ready interrupt request |

## Verification
Register contents, `rww_blocked` and every pulse output (`cmd_*`, `buf_clear`, `lpm_*`) are registered. Each of them is due one cycle after the edge that samples its cause. `spm_irq` follows the register state in the same cycle. The bench drives inputs one nanosecond after a rising edge and samples one nanosecond after the next rising edge, so each check sees exactly the result of one edge. Window limits are probed by counting idle edges before the strobe: the fourth edge must still accept, and the edge after expiry must already show the cleared register.

// File: rtl/flash_selfprog_pkg.sv
package flash_selfprog_pkg;
  localparam int REG_W   = 8;
  localparam int B_IE    = 7;
  localparam int B_BUSY  = 6;
  localparam int B_RSVD  = 5;
  localparam int B_RRE   = 4;
  localparam int B_LOCK  = 3;
  localparam int B_WRITE = 2;
  localparam int B_ERASE = 1;
  localparam int B_EN    = 0;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_RWWEN = 3'd1,
    OP_LOCK  = 3'd2,
    OP_ERASE = 3'd3,
    OP_WRITE = 3'd4
  } op_kind_e;
endpackage

// File: rtl/fsp_window.sv
module fsp_window #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  output logic open,
  output logic expire
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(DEPTH);

  logic [CW-1:0] cnt;

  assign open   = (cnt != '0);
  assign expire = (cnt == CW'(1)) && !hit && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (start)           cnt <= LOAD_V;
    else if (hit)             cnt <= '0;
    else if (cnt != '0)       cnt <= cnt - CW'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_V);
  // R3
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !open);
endmodule

// File: rtl/fsp_cmd_arbiter.sv
module fsp_cmd_arbiter
  import flash_selfprog_pkg::*;
(
  input  logic     want_rre,
  input  logic     want_lock,
  input  logic     want_erase,
  input  logic     want_write,
  output op_kind_e kind
);
  // R4: fixed order, first match wins
  always_comb begin
    if (want_rre)        kind = OP_RWWEN;
    else if (want_lock)  kind = OP_LOCK;
    else if (want_erase) kind = OP_ERASE;
    else if (want_write) kind = OP_WRITE;
    else                 kind = OP_LOAD;
  end
endmodule

// File: rtl/fsp_busy_track.sv
module fsp_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_busy,
  input  logic clr_busy,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (clr_busy) busy <= 1'b0;
    else if (set_busy) busy <= 1'b1;
  end
endmodule

// File: rtl/flash_selfprog_ctl.sv
module flash_selfprog_ctl
  import flash_selfprog_pkg::*;
#(
  parameter int SPM_WINDOW = 4,
  parameter int LPM_WINDOW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             spm_strobe,
  input  logic             lpm_strobe,
  input  logic             lpm_z0,
  input  logic             z_in_rww,
  input  logic             global_ie,
  input  logic             flash_done,
  input  logic             buf_loading,
  output logic             cmd_load,
  output logic             cmd_erase,
  output logic             cmd_write,
  output logic             cmd_lock,
  output logic             cmd_rww_en,
  output logic             rww_blocked,
  output logic             buf_clear,
  output logic             lpm_lock_rd,
  output logic             lpm_fuse_rd,
  output logic             spm_irq
);
  logic ie_q, rre_q, lock_q, write_q, erase_q, en_q, running_q;
  logic busy;
  logic accept_wr, start, fire, long_op, instant, done, clear_all;
  logic spm_open, spm_expire, lpm_open, lpm_expire_unused;
  op_kind_e kind;

  assign accept_wr = reg_we && !en_q;
  assign start     = accept_wr && reg_wdata[B_EN];
  assign fire      = spm_open && spm_strobe;
  assign long_op   = fire && (kind == OP_LOCK || kind == OP_ERASE || kind == OP_WRITE);
  assign instant   = fire && (kind == OP_LOAD || kind == OP_RWWEN);
  assign done      = running_q && flash_done;
  assign clear_all = instant || done || spm_expire;

  fsp_window #(.DEPTH(SPM_WINDOW)) u_spm_win (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(fire),
    .open(spm_open), .expire(spm_expire)
  );

  fsp_window #(.DEPTH(LPM_WINDOW)) u_lpm_win (
    .clk(clk), .rst_n(rst_n), .start(start && reg_wdata[B_LOCK]), .hit(1'b0),
    .open(lpm_open), .expire(lpm_expire_unused)
  );

  fsp_cmd_arbiter u_arb (
    .want_rre(rre_q), .want_lock(lock_q), .want_erase(erase_q),
    .want_write(write_q), .kind(kind)
  );

  fsp_busy_track u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_busy(long_op && z_in_rww && (kind == OP_ERASE || kind == OP_WRITE)),
    .clr_busy(instant),
    .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; rre_q <= 1'b0; lock_q <= 1'b0; write_q <= 1'b0;
      erase_q <= 1'b0; en_q <= 1'b0; running_q <= 1'b0;
    end else begin
      if (reg_we) ie_q <= reg_wdata[B_IE];
      if (start) begin
        rre_q   <= reg_wdata[B_RRE];
        lock_q  <= reg_wdata[B_LOCK];
        write_q <= reg_wdata[B_WRITE];
        erase_q <= reg_wdata[B_ERASE];
        en_q    <= 1'b1;
      end else if (clear_all) begin
        rre_q <= 1'b0; lock_q <= 1'b0; write_q <= 1'b0;
        erase_q <= 1'b0; en_q <= 1'b0; running_q <= 1'b0;
      end else if (long_op) begin
        running_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_load <= 1'b0; cmd_erase <= 1'b0; cmd_write <= 1'b0;
      cmd_lock <= 1'b0; cmd_rww_en <= 1'b0; buf_clear <= 1'b0;
      lpm_lock_rd <= 1'b0; lpm_fuse_rd <= 1'b0;
    end else begin
      cmd_load    <= fire && kind == OP_LOAD;
      cmd_rww_en  <= fire && kind == OP_RWWEN;
      cmd_lock    <= fire && kind == OP_LOCK;
      cmd_erase   <= fire && kind == OP_ERASE;
      cmd_write   <= fire && kind == OP_WRITE;
      buf_clear   <= reg_we && reg_wdata[B_RRE] && buf_loading;
      lpm_lock_rd <= lpm_strobe && lpm_open && lock_q && en_q && !lpm_z0;
      lpm_fuse_rd <= lpm_strobe && lpm_open && lock_q && en_q && lpm_z0;
    end
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_IE]    = ie_q;
    reg_rdata[B_BUSY]  = busy;
    reg_rdata[B_RRE]   = rre_q;
    reg_rdata[B_LOCK]  = lock_q;
    reg_rdata[B_WRITE] = write_q;
    reg_rdata[B_ERASE] = erase_q;
    reg_rdata[B_EN]    = en_q;
  end

  assign rww_blocked = busy;
  assign spm_irq     = ie_q && global_ie && !en_q;

  // R4
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_load, cmd_erase, cmd_write, cmd_lock, cmd_rww_en}));
  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load || cmd_erase || cmd_write || cmd_lock || cmd_rww_en) |-> $past(spm_strobe));
  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && flash_done) |=> !en_q);
  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && reg_we && !clear_all) |=>
      ({rre_q, lock_q, write_q, erase_q} == $past({rre_q, lock_q, write_q, erase_q})));
  // R7
  load_unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load || cmd_rww_en) |-> !rww_blocked);
endmodule

// File: tb/flash_selfprog_ctl_bench.sv
module flash_selfprog_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 0, spm_strobe = 0, lpm_strobe = 0, lpm_z0 = 0, z_in_rww = 0;
  logic global_ie = 0, flash_done = 0, buf_loading = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cmd_load, cmd_erase, cmd_write, cmd_lock, cmd_rww_en;
  logic rww_blocked, buf_clear, lpm_lock_rd, lpm_fuse_rd, spm_irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_selfprog_ctl u_flash_selfprog_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
    .lpm_z0(lpm_z0), .z_in_rww(z_in_rww), .global_ie(global_ie),
    .flash_done(flash_done), .buf_loading(buf_loading), .cmd_load(cmd_load),
    .cmd_erase(cmd_erase), .cmd_write(cmd_write), .cmd_lock(cmd_lock),
    .cmd_rww_en(cmd_rww_en), .rww_blocked(rww_blocked), .buf_clear(buf_clear),
    .lpm_lock_rd(lpm_lock_rd), .lpm_fuse_rd(lpm_fuse_rd), .spm_irq(spm_irq)
  );

  // {wdata, global_ie, expected rdata, expected irq}
  localparam logic [17:0] VECS [0:4] = '{
    {8'h80, 1'b1, 8'h80, 1'b1},
    {8'h80, 1'b0, 8'h80, 1'b0},
    {8'h00, 1'b1, 8'h00, 1'b0},
    {8'hFE, 1'b1, 8'h80, 1'b1},
    {8'h7E, 1'b1, 8'h00, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1; reg_wdata = v; tick(); reg_we = 0;
  endtask

  task automatic spm_now();
    spm_strobe = 1; tick(); spm_strobe = 0;
  endtask

  function automatic logic [7:0] cmds();
    return {3'b0, cmd_load, cmd_erase, cmd_write, cmd_lock, cmd_rww_en};
  endfunction

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk(reg_rdata, 8'h00, "R1 reset rdata");
    chk({spm_irq, rww_blocked, cmds()}, 8'h00, "R1 reset outputs");

    // R1 / R11 vector walk
    foreach (VECS[i]) begin
      global_ie = VECS[i][9];
      wr(VECS[i][17:10]);
      chk(reg_rdata, VECS[i][8:1], "R1 vector rdata");
      chk({7'b0, spm_irq}, {7'b0, VECS[i][0]}, "R11 vector irq");
    end

    // R2 R5 R6 R8 R11: erase on rww section, strobe at second edge
    global_ie = 1; z_in_rww = 1;
    wr(8'h83);
    chk({7'b0, spm_irq}, 8'h00, "R11 irq low while enabled");
    tick();
    spm_now();
    chk(cmds(), 8'h08, "R2 erase pulse");
    chk(reg_rdata, 8'hC3, "R5 busy set by erase");
    chk({7'b0, rww_blocked}, 8'h01, "R5 rww blocked");
    tick();
    chk(cmds(), 8'h00, "R2 pulse lasts one cycle");
    wr(8'h11);
    chk(reg_rdata, 8'h43, "R8 write ignored while enabled");
    tick(); tick();
    chk(reg_rdata, 8'h43, "R6 enable held until done");
    flash_done = 1; tick(); flash_done = 0;
    chk(reg_rdata, 8'h40, "R6 cleared by done");
    chk({7'b0, spm_irq}, 8'h00, "R11 irq needs ie");

    // R7 re-enable with strobe at the fourth edge
    wr(8'h11);
    tick(); tick(); tick();
    spm_now();
    chk(cmds(), 8'h01, "R7 rww enable pulse at edge 4");
    chk(reg_rdata, 8'h00, "R7 busy cleared");

    // R3 window expiry
    wr(8'h05);
    tick(); tick(); tick();
    chk(reg_rdata, 8'h05, "R3 still armed after 3 edges");
    tick();
    chk(reg_rdata, 8'h00, "R3 expired after 4 edges");
    spm_now();
    chk(cmds(), 8'h00, "R3 no pulse after expiry");

    // R4 priority
    wr(8'h1F); spm_now();
    chk(cmds(), 8'h01, "R4 rre wins");
    chk(reg_rdata, 8'h00, "R4 rre ends at once");
    wr(8'h0F); spm_now();
    chk(cmds(), 8'h02, "R4 lock wins over erase/write");
    chk(reg_rdata, 8'h0F, "R6 lock held");
    flash_done = 1; tick(); flash_done = 0;
    chk(reg_rdata, 8'h00, "R6 lock self-clears");

    // R5 write outside rww section
    z_in_rww = 0;
    wr(8'h05); spm_now();
    chk(cmds(), 8'h04, "R5 write pulse");
    chk({7'b0, rww_blocked}, 8'h00, "R5 non-rww leaves busy");
    flash_done = 1; tick(); flash_done = 0;

    // R7 page load clears busy
    z_in_rww = 1;
    wr(8'h05); spm_now();
    flash_done = 1; tick(); flash_done = 0;
    chk(reg_rdata, 8'h40, "R5 busy after rww write");
    wr(8'h01); spm_now();
    chk(cmds(), 8'h10, "R4 load pulse");
    chk(reg_rdata, 8'h00, "R7 load clears busy");

    // R9 buffer clear
    buf_loading = 1;
    wr(8'h10);
    chk({7'b0, buf_clear}, 8'h01, "R9 buffer clear pulse");
    tick();
    chk({7'b0, buf_clear}, 8'h00, "R9 pulse one cycle");
    buf_loading = 0;
    wr(8'h10);
    chk({7'b0, buf_clear}, 8'h00, "R9 no clear when not loading");

    // R10 lpm window
    wr(8'h09);
    lpm_z0 = 0; lpm_strobe = 1; tick();
    chk({6'b0, lpm_fuse_rd, lpm_lock_rd}, 8'h01, "R10 lock read");
    lpm_z0 = 1; tick();
    chk({6'b0, lpm_fuse_rd, lpm_lock_rd}, 8'h02, "R10 fuse read");
    tick();
    chk({6'b0, lpm_fuse_rd, lpm_lock_rd}, 8'h02, "R10 third edge");
    tick(); lpm_strobe = 0;
    chk({6'b0, lpm_fuse_rd, lpm_lock_rd}, 8'h00, "R10 closed at fourth edge");
    chk(reg_rdata, 8'h00, "R3 lock arm expired");

    // R11 irq after completion
    wr(8'h80);
    chk({7'b0, spm_irq}, 8'h01, "R11 irq when idle");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule